// File: doc/BRIEF.md
# Memory-mapped FIFO read port

This block is a bus slave that buffers 32-bit words in an internal first-in first-out store. A producer in the same clock domain pushes words through a plain data and write-enable port. A processor or DMA engine drains them through a memory-mapped read interface made of a read strobe, read data and a wait signal. The head word is always presented show-ahead on the read data. A read that finds a word completes in its first cycle with no wait state.

Every read strobe removes exactly one word, however long the master keeps the strobe high. A read that arrives while the store is empty is held off with the wait signal until a word lands, so the reader never sees stale data and the store never underflows. The block also brings out a level flag for software to poll before it starts a block read, the live occupancy count, and a sticky flag that records words dropped because the store was full.

Top module: `mm_fifo_rd_port`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the store is empty: `level_o` is 0, `half_o` and `ovf_o` are 0, `rd_data_o` is 0, and `wait_o` is 0 while `rd_i` is low.
- R2: Successive accepted reads return the words in exactly the order they were written. A counter pattern reads back as consecutive values.
- R3: While `level_o` is non-zero, `rd_data_o` already carries the oldest stored word, and a fresh read strobe sees `wait_o` low in its first cycle.
- R4: A read strobe pops exactly one word, even when `rd_i` stays high for several cycles. A further pop needs `rd_i` to be low across at least one clock edge.
- R5: A fresh read while `level_o` is 0 drives `wait_o` high and pops nothing. The stall ends in the cycle after a write lands, and that read is then accepted at the next edge.
- R6: `half_o` is high exactly while `level_o` is at least DEPTH/2 (32 with the defaults).
- R7: A write while `level_o` equals DEPTH (64) is dropped, so level and contents stay unchanged. The drop sets `ovf_o`, which stays high until reset.
- R8: A write and an accepted read in the same cycle leave `level_o` unchanged and keep the data order.
- R9: A read is accepted at the clock edge where `rd_i` is high and `wait_o` is low in a fresh strobe. In the following cycle `level_o` has dropped by one and `rd_data_o` shows the next word.
- R10: While `level_o` is 0, `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock for both sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 32 | Word to store |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| rd_i | input | 1 | Bus read strobe |
| rd_data_o | output | 32 | Head word, show-ahead |
| wait_o | output | 1 | Stalls the bus read while the store is empty |
| half_o | output | 1 | Occupancy at or above half of DEPTH |
| ovf_o | output | 1 | Sticky: a write was dropped while full |
| level_o | output | 7 | Current number of stored words |

## Verification
Two pairs of functions can fall in the same cycle. A producer write can coincide with an accepted pop. A producer write can also land while a read sits stalled on an empty store. The bench provokes the first by raising the write strobe and a fresh read strobe for the same edge with two words stored. It judges the result by an unchanged level and by the later read-out order. It provokes the second by holding a read against an empty store over several cycles and then writing one word. It expects the wait signal to drop in the next cycle and exactly one pop at the edge after that.

// File: rtl/mm_fifo_pkg.sv
package mm_fifo_pkg;
  parameter int unsigned DATA_W_DEF = 32;
  parameter int unsigned DEPTH_DEF  = 64;

  function automatic int unsigned lvl_w(input int unsigned depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/mm_fifo_ram.sv
module mm_fifo_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // asynchronous read gives the show-ahead head word
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mm_fifo_ctrl.sv
module mm_fifo_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          pop_i,
  output logic          push_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] level_o,
  output logic          empty_o,
  output logic          ovf_o
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_o  = wr_en_i & ~full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      unique case ({push_o, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (wr_en_i && full) ovf_q <= 1'b1;
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_ptr_o = rd_ptr_q;
  assign level_o  = cnt_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/mm_fifo_bus.sv
module mm_fifo_bus (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic empty_i,
  output logic pop_o,
  output logic wait_o
);
  // armed: current strobe has not popped yet
  logic armed_q;

  assign pop_o  = rd_i & armed_q & ~empty_i;
  assign wait_o = rd_i & armed_q & empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b1;
    else if (!rd_i)  armed_q <= 1'b1;
    else if (pop_o)  armed_q <= 1'b0;
  end
endmodule

// File: rtl/mm_fifo_rd_port.sv
module mm_fifo_rd_port
  import mm_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = lvl_w(DEPTH),
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wait_o,
  output logic              half_o,
  output logic              ovf_o,
  output logic [CW-1:0]     level_o
);
  logic              push, pop, empty;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [DATA_W-1:0] head;

  mm_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .pop_i    (pop),
    .push_o   (push),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .level_o  (level_o),
    .empty_o  (empty),
    .ovf_o    (ovf_o)
  );

  mm_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wr_ptr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (head)
  );

  mm_fifo_bus u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .empty_i (empty),
    .pop_o   (pop),
    .wait_o  (wait_o)
  );

  // mask unwritten or stale storage while empty
  assign rd_data_o = empty ? '0 : head;
  assign half_o    = (level_o >= CW'(HALF));
endmodule

// File: rtl/mm_fifo_rd_port_chk.sv
module mm_fifo_rd_port_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned CW    = $clog2(DEPTH) + 1,
  localparam int unsigned HALF  = DEPTH / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wr_en_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wait_o,
  input logic              half_o,
  input logic              ovf_o,
  input logic [CW-1:0]     level_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r10_zero_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> (rd_data_o == '0));

  a_r5_stall_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && level_o == '0 && seen_q && !$past(rd_i)) |-> wait_o);

  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0 && !wr_en_i) |=> (level_o == '0));

  a_r6_half_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(half_o)) |-> (level_o == CW'(HALF)));

  a_r6_half_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(half_o)) |-> (level_o == CW'(HALF - 1)));

  a_r7_level_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH));

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r4_single_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rd_i && $past(rd_i) && !$past(wait_o) && !wr_en_i) |=> $stable(level_o));

  a_r9_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rd_i && !wait_o && level_o != '0 && (!$past(rd_i) || $past(wait_o)) && !wr_en_i)
      |=> (level_o == $past(level_o) - 1'b1));

  a_r8_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rd_i && level_o != '0 && level_o != CW'(DEPTH) && (!$past(rd_i) || $past(wait_o)) && wr_en_i)
      |=> $stable(level_o));
endmodule

bind mm_fifo_rd_port mm_fifo_rd_port_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_data_i (wr_data_i),
  .wr_en_i   (wr_en_i),
  .rd_i      (rd_i),
  .rd_data_o (rd_data_o),
  .wait_o    (wait_o),
  .half_o    (half_o),
  .ovf_o     (ovf_o),
  .level_o   (level_o)
);

// File: tb/mm_fifo_rd_port_bench.sv
module mm_fifo_rd_port_bench;
  localparam int unsigned DW = 32;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned CW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_en = 1'b0;
  logic          rd = 1'b0;
  logic [DW-1:0] rd_data;
  logic          wait_s, half, ovf;
  logic [CW-1:0] level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] model_q[$];

  always #2.5 clk = ~clk;

  mm_fifo_rd_port u_mm_fifo_rd_port (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_data_i (wr_data),
    .wr_en_i   (wr_en),
    .rd_i      (rd),
    .rd_data_o (rd_data),
    .wait_o    (wait_s),
    .half_o    (half),
    .ovf_o     (ovf),
    .level_o   (level)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [DW-1:0] d);
    wr_en = 1'b1;
    wr_data = d;
    if (model_q.size() < DEPTH) model_q.push_back(d);
    step();
    wr_en = 1'b0;
  endtask

  // single-cycle strobe, checks head before accept and level after
  task automatic pop_one(input string tag);
    logic [DW-1:0] exp;
    int lv;
    exp = model_q.pop_front();
    lv = model_q.size();
    rd = 1'b1;
    #1;
    chk({tag, " R3 wait low"}, DW'(wait_s), 0);
    chk({tag, " R2 head word"}, rd_data, exp);
    step();
    rd = 1'b0;
    chk({tag, " R9 level after pop"}, DW'(level), DW'(lv));
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    model_q.delete();
    step();
    step();
    chk("R1 level in reset", DW'(level), 0);
    chk("R1 ovf in reset", DW'(ovf), 0);
    rst_n = 1'b1;
    step();
    chk("R1 level", DW'(level), 0);
    chk("R1 half", DW'(half), 0);
    chk("R1 ovf", DW'(ovf), 0);
    chk("R1 wait", DW'(wait_s), 0);
    chk("R10 data zero empty", rd_data, 0);
  endtask

  task automatic t_order();
    for (int i = 1; i <= 5; i++) push(DW'(i));
    chk("R2 level after writes", DW'(level), 5);
    for (int i = 0; i < 5; i++) pop_one("R2 order");
    chk("R10 data zero after drain", rd_data, 0);
  endtask

  task automatic t_held();
    push(32'hA1); push(32'hA2); push(32'hA3);
    rd = 1'b1;
    step();
    void'(model_q.pop_front());
    for (int c = 0; c < 3; c++) begin
      chk("R4 held strobe level", DW'(level), 2);
      chk("R4 held strobe wait", DW'(wait_s), 0);
      chk("R9 next head shown", rd_data, 32'hA2);
      step();
    end
    rd = 1'b0;
    step();
    chk("R4 no extra pop", DW'(level), 2);
    pop_one("R4 rearmed");
    pop_one("R4 rearmed");
  endtask

  task automatic t_empty_stall();
    rd = 1'b1;
    #1;
    chk("R5 wait on empty", DW'(wait_s), 1);
    for (int c = 0; c < 3; c++) begin
      step();
      chk("R5 still stalled", DW'(wait_s), 1);
      chk("R5 nothing popped", DW'(level), 0);
    end
    wr_en = 1'b1;
    wr_data = 32'hBEEF;
    step();
    wr_en = 1'b0;
    #1;
    chk("R5 stall released", DW'(wait_s), 0);
    chk("R5 word presented", rd_data, 32'hBEEF);
    step();
    chk("R5 stalled read popped", DW'(level), 0);
    chk("R5 no second pop wait", DW'(wait_s), 0);
    rd = 1'b0;
    step();
  endtask

  task automatic t_half();
    for (int i = 0; i < 31; i++) push(DW'(32'h200 + i));
    chk("R6 half at 31", DW'(half), 0);
    push(32'h21F);
    chk("R6 half at 32", DW'(half), 1);
    pop_one("R6");
    chk("R6 half at 31 again", DW'(half), 0);
    while (model_q.size() > 0) pop_one("R6 drain");
  endtask

  task automatic t_full();
    for (int i = 0; i < 64; i++) push(DW'(32'h100 + i));
    chk("R7 level full", DW'(level), 64);
    chk("R7 ovf before drop", DW'(ovf), 0);
    push(32'hDEAD);
    chk("R7 level after drop", DW'(level), 64);
    chk("R7 ovf set", DW'(ovf), 1);
    while (model_q.size() > 0) pop_one("R7 drain");
    chk("R7 dropped word absent", DW'(level), 0);
    chk("R7 ovf sticky", DW'(ovf), 1);
  endtask

  task automatic t_both();
    push(32'hC1); push(32'hC2);
    rd = 1'b1;
    wr_en = 1'b1;
    wr_data = 32'hC3;
    void'(model_q.pop_front());
    model_q.push_back(32'hC3);
    step();
    rd = 1'b0;
    wr_en = 1'b0;
    chk("R8 level unchanged", DW'(level), 2);
    chk("R8 next head", rd_data, 32'hC2);
    step();
    pop_one("R8 order");
    pop_one("R8 order");
  endtask

  initial begin
    t_reset();
    t_order();
    t_held();
    t_empty_stall();
    t_half();
    t_both();
    t_full();
    t_reset();
    chk("R1 ovf cleared by reset", DW'(ovf), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule